// File: doc/BRIEF.md
# Register Bank and Arithmetic Datapath

This block is the execute-side datapath of a small 16-bit processor. It keeps eight general registers that can be read through two independent ports and written through one port. Both read values go straight into an arithmetic/logic unit. A 3-bit operation code selects one of eight functions: idle, add, subtract, multiply, NAND, left shift, right shift and test.

The single write port takes its value from one of two sources. One is an external data input, used to preload registers before a program reads them. The other is the current ALU result, which gives a write-back path. Multiplication forms a full-width signed product: the low half is the result and the high half appears on its own output. A test operation updates a registered zero flag and a registered negative flag from the first operand. All other operations leave the flags as they are.

Storage, the write-back path, the flags and the product-high output all run on one clock with one synchronous reset. Widths, register count and the shifter build style are parameters.

Top module: `dp_core`

## Requirements
- R1: A synchronous reset clears every register to 0 and clears both flags. After reset, every read returns 0 and `flag_z` and `flag_n` are 0.
- R2: When `wr_en` is 1, the rising clock edge stores the selected write value into the register chosen by `wr_sel`. When `wr_en` is 0, no register changes.
- R3: Reads are combinational. `rd_val_a` and `rd_val_b` show the registers selected by `rd_sel_a` and `rd_sel_b`, independently of each other.
- R4: If a read selects the register being written in the same cycle, the read returns the old value. From the next cycle on, it returns the new value.
- R5: Op code 1 gives A+B and op code 2 gives A-B. Both use signed two's-complement arithmetic and wrap to 16 bits. A-A is always 0.
- R6: Op code 3 forms the signed 32-bit product A*B. `result` carries bits 15..0 and `prod_hi` carries bits 31..16. For every other op code, `prod_hi` is 0.
- R7: Op code 4 gives the bitwise NAND of A and B.
- R8: Op codes 5 and 6 shift A logically left and right, respectively. The shift amount is B[3:0], and vacated bits fill with zeros. An amount of 0 returns A unchanged.
- R9: Op code 7 drives `result` to 0. At the next clock edge it loads `flag_z` with (A==0) and `flag_n` with A[15].
- R10: Op code 0 drives `result` and `prod_hi` to 0. No op code other than 7 changes the flags.
- R11: `wr_src` picks the write value: 0 selects `ext_data` and 1 selects the current ALU `result`, which gives write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_sel_a | input | 3 | Register index for operand A |
| rd_sel_b | input | 3 | Register index for operand B |
| wr_sel | input | 3 | Register index for the write |
| wr_en | input | 1 | Write enable |
| wr_src | input | 1 | Write value source: 0 external, 1 ALU result |
| ext_data | input | 16 | External value for preloading registers |
| op | input | 3 | Operation code (0 idle … 7 test) |
| rd_val_a | output | 16 | Register value at read port A |
| rd_val_b | output | 16 | Register value at read port B |
| result | output | 16 | ALU result (low half of the product for multiply) |
| prod_hi | output | 16 | High half of the signed product |
| flag_z | output | 1 | Registered zero flag |
| flag_n | output | 1 | Registered negative flag |

## Verification
Two functions can land in the same cycle: a register write, and a read or ALU operation that uses that same register. The bench provokes this in two ways. First, it writes a register while read port A points at it. Second, it writes an ADD result back into one of the ADD's own source registers. In both cases it checks the combinational outputs before the clock edge against the old contents, and the outputs after the edge against the new contents. For the write-back case, it also checks that the new sum is built from the value just written.

// File: rtl/dp_core_pkg.sv
package dp_core_pkg;

   typedef enum logic [2:0] {
      OP_IDLE = 3'd0,
      OP_ADD  = 3'd1,
      OP_SUB  = 3'd2,
      OP_MUL  = 3'd3,
      OP_NAND = 3'd4,
      OP_SHL  = 3'd5,
      OP_SHR  = 3'd6,
      OP_TEST = 3'd7
   } alu_op_e;

   typedef enum logic {
      SRC_EXT = 1'b0,
      SRC_ALU = 1'b1
   } wr_src_e;

   typedef enum logic {
      SHIFT_BARREL = 1'b0,
      SHIFT_LOOP   = 1'b1
   } shift_style_e;

endpackage

// File: rtl/dp_regbank.sv
module dp_regbank #(
   parameter int DATA_W = 16,
   parameter int NREGS  = 8,
   localparam int IDX_W = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [IDX_W-1:0]  rd_sel_a,
   input  logic [IDX_W-1:0]  rd_sel_b,
   input  logic [IDX_W-1:0]  wr_sel,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_a,
   output logic [DATA_W-1:0] rd_b
);

   logic [NREGS-1:0][DATA_W-1:0] mem;

   always_ff @(posedge clk) begin
      if (rst) begin
         mem <= '0;
      end else if (wr_en) begin
         mem[wr_sel] <= wr_data;
      end
   end

   assign rd_a = mem[rd_sel_a];
   assign rd_b = mem[rd_sel_b];

   // R1
   reset_clear_chk: assert property (@(posedge clk) rst |=> (mem == '0));

   // R2
   write_store_chk: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> (mem[$past(wr_sel)] == $past(wr_data)));

   // R2
   write_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(mem));

   // R4
   read_after_write_chk: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> ((rd_sel_a != $past(wr_sel)) || (rd_a == $past(wr_data))));

endmodule

// File: rtl/dp_shifter.sv
module dp_shifter #(
   parameter int DATA_W = 16,
   parameter bit LEFT   = 1'b1,
   parameter dp_core_pkg::shift_style_e STYLE = dp_core_pkg::SHIFT_BARREL,
   localparam int SH_W  = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] din,
   input  logic [SH_W-1:0]   amt,
   output logic [DATA_W-1:0] dout
);

   generate
      if (STYLE == dp_core_pkg::SHIFT_BARREL) begin : g_barrel
         logic [DATA_W-1:0] stg [0:SH_W];
         assign stg[0] = din;
         for (genvar k = 0; k < SH_W; k++) begin : g_stage
            if (LEFT) begin : g_l
               assign stg[k+1] = amt[k] ? (stg[k] << (1 << k)) : stg[k];
            end else begin : g_r
               assign stg[k+1] = amt[k] ? (stg[k] >> (1 << k)) : stg[k];
            end
         end
         assign dout = stg[SH_W];
      end else begin : g_loop
         always_comb begin
            dout = din;
            for (int i = 0; i < DATA_W; i++) begin
               if (i < int'(amt)) begin
                  dout = LEFT ? (dout << 1) : (dout >> 1);
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/dp_alu.sv
module dp_alu #(
   parameter int DATA_W = 16,
   parameter dp_core_pkg::shift_style_e SHIFT_STYLE = dp_core_pkg::SHIFT_BARREL,
   localparam int SH_W  = $clog2(DATA_W),
   localparam int PROD_W = 2 * DATA_W
) (
   input  logic                 clk,
   input  logic                 rst,
   input  dp_core_pkg::alu_op_e op,
   input  logic [DATA_W-1:0]    a,
   input  logic [DATA_W-1:0]    b,
   output logic [DATA_W-1:0]    result,
   output logic [DATA_W-1:0]    prod_hi,
   output logic                 flag_z,
   output logic                 flag_n
);
   import dp_core_pkg::*;

   logic signed [PROD_W-1:0] prod;
   logic [DATA_W-1:0]        shl_out;
   logic [DATA_W-1:0]        shr_out;

   assign prod = $signed(a) * $signed(b);

   dp_shifter #(.DATA_W(DATA_W), .LEFT(1'b1), .STYLE(SHIFT_STYLE)) u_shl (
      .din(a), .amt(b[SH_W-1:0]), .dout(shl_out));

   dp_shifter #(.DATA_W(DATA_W), .LEFT(1'b0), .STYLE(SHIFT_STYLE)) u_shr (
      .din(a), .amt(b[SH_W-1:0]), .dout(shr_out));

   always_comb begin
      result  = '0;
      prod_hi = '0;
      case (op)
         OP_ADD:  result = a + b;
         OP_SUB:  result = a - b;
         OP_MUL: begin
            result  = prod[DATA_W-1:0];
            prod_hi = prod[PROD_W-1:DATA_W];
         end
         OP_NAND: result = ~(a & b);
         OP_SHL:  result = shl_out;
         OP_SHR:  result = shr_out;
         default: result = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         flag_z <= 1'b0;
         flag_n <= 1'b0;
      end else if (op == OP_TEST) begin
         flag_z <= (a == '0);
         flag_n <= a[DATA_W-1];
      end
   end

   // R5
   sub_self_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (op == OP_SUB && a == b) |-> (result == '0));

   // R6
   hi_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (op != OP_MUL) |-> (prod_hi == '0));

   // R8
   shift_nil_chk: assert property (@(posedge clk) disable iff (rst)
      ((op == OP_SHL || op == OP_SHR) && b[SH_W-1:0] == '0) |-> (result == a));

   // R8
   shr_fill_chk: assert property (@(posedge clk) disable iff (rst)
      (op == OP_SHR && b[SH_W-1:0] != '0) |-> !result[DATA_W-1]);

   // R9
   test_flag_chk: assert property (@(posedge clk) disable iff (rst)
      (op == OP_TEST) |=> (flag_z == ($past(a) == '0)) && (flag_n == $past(a[DATA_W-1])));

   // R9
   test_result_chk: assert property (@(posedge clk) disable iff (rst)
      (op == OP_TEST) |-> (result == '0));

   // R10
   flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (op != OP_TEST) |=> ($stable(flag_z) && $stable(flag_n)));

   // R10
   idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (op == OP_IDLE) |-> (result == '0 && prod_hi == '0));

endmodule

// File: rtl/dp_core.sv
module dp_core #(
   parameter int DATA_W = 16,
   parameter int NREGS  = 8,
   parameter dp_core_pkg::shift_style_e SHIFT_STYLE = dp_core_pkg::SHIFT_BARREL,
   localparam int IDX_W = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [IDX_W-1:0]  rd_sel_a,
   input  logic [IDX_W-1:0]  rd_sel_b,
   input  logic [IDX_W-1:0]  wr_sel,
   input  logic              wr_en,
   input  logic              wr_src,
   input  logic [DATA_W-1:0] ext_data,
   input  logic [2:0]        op,
   output logic [DATA_W-1:0] rd_val_a,
   output logic [DATA_W-1:0] rd_val_b,
   output logic [DATA_W-1:0] result,
   output logic [DATA_W-1:0] prod_hi,
   output logic              flag_z,
   output logic              flag_n
);
   import dp_core_pkg::*;

   generate
      if (DATA_W < 4 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("dp_core: DATA_W must be a power of two, at least 4");
      end
      if (NREGS < 2 || (NREGS & (NREGS - 1)) != 0) begin : g_bad_depth
         $error("dp_core: NREGS must be a power of two, at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] wr_data;
   logic [DATA_W-1:0] alu_res;
   alu_op_e           op_e;

   assign op_e     = alu_op_e'(op);
   assign wr_data  = (wr_src_e'(wr_src) == SRC_ALU) ? alu_res : ext_data;
   assign result   = alu_res;

   dp_regbank #(.DATA_W(DATA_W), .NREGS(NREGS)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .rd_sel_a (rd_sel_a),
      .rd_sel_b (rd_sel_b),
      .wr_sel   (wr_sel),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .rd_a     (rd_val_a),
      .rd_b     (rd_val_b)
   );

   dp_alu #(.DATA_W(DATA_W), .SHIFT_STYLE(SHIFT_STYLE)) u_alu (
      .clk     (clk),
      .rst     (rst),
      .op      (op_e),
      .a       (rd_val_a),
      .b       (rd_val_b),
      .result  (alu_res),
      .prod_hi (prod_hi),
      .flag_z  (flag_z),
      .flag_n  (flag_n)
   );

   // R11
   writeback_src_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_src && op == 3'd0) |=> (rd_val_a == '0 || rd_sel_a != $past(wr_sel)));

endmodule

// File: tb/tb_dp_core.sv
module tb_dp_core;

   logic        clk = 1'b0;
   logic        rst;
   logic [2:0]  rd_sel_a, rd_sel_b, wr_sel;
   logic        wr_en, wr_src;
   logic [15:0] ext_data;
   logic [2:0]  op;
   logic [15:0] rd_val_a, rd_val_b, result, prod_hi;
   logic        flag_z, flag_n;

   int checks   = 0;
   int failures = 0;

   always #10 clk = ~clk;

   dp_core dut (
      .clk(clk), .rst(rst), .rd_sel_a(rd_sel_a), .rd_sel_b(rd_sel_b),
      .wr_sel(wr_sel), .wr_en(wr_en), .wr_src(wr_src), .ext_data(ext_data),
      .op(op), .rd_val_a(rd_val_a), .rd_val_b(rd_val_b), .result(result),
      .prod_hi(prod_hi), .flag_z(flag_z), .flag_n(flag_n)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic load_reg(input logic [2:0] idx, input logic [15:0] val);
      @(negedge clk);
      wr_sel = idx; ext_data = val; wr_src = 1'b0; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_ops(input logic [2:0] ia, input logic [2:0] ib, input logic [2:0] code);
      @(negedge clk);
      rd_sel_a = ia; rd_sel_b = ib; op = code;
      #2;
   endtask

   task automatic t_reset;
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      for (int i = 0; i < 8; i++) begin
         rd_sel_a = 3'(i); rd_sel_b = 3'(7 - i); #1;
         chk("R1 reg a", {16'h0, rd_val_a}, 32'h0);
         chk("R1 reg b", {16'h0, rd_val_b}, 32'h0);
      end
      chk("R1 flags", {30'h0, flag_z, flag_n}, 32'h0);
   endtask

   task automatic t_fill_read;
      for (int i = 0; i < 8; i++) load_reg(3'(i), 16'h1000 + 16'(i * 16'h0111));
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); rd_sel_a = 3'(i); rd_sel_b = 3'((i + 3) % 8); #2;
         chk("R3 port a", {16'h0, rd_val_a}, {16'h0, 16'h1000 + 16'(i * 16'h0111)});
         chk("R3 port b", {16'h0, rd_val_b}, {16'h0, 16'h1000 + 16'(((i + 3) % 8) * 16'h0111)});
      end
   endtask

   task automatic t_write_gate;
      @(negedge clk);
      wr_sel = 3'd4; ext_data = 16'hDEAD; wr_src = 1'b0; wr_en = 1'b0;
      @(negedge clk); rd_sel_a = 3'd4; #2;
      chk("R2 disabled write", {16'h0, rd_val_a}, {16'h0, 16'h1444});
      load_reg(3'd4, 16'hBEEF);
      #2;
      chk("R2 enabled write", {16'h0, rd_val_a}, {16'h0, 16'hBEEF});
   endtask

   task automatic t_same_cycle;
      load_reg(3'd2, 16'h1111);
      @(negedge clk);
      rd_sel_a = 3'd2; wr_sel = 3'd2; ext_data = 16'h2222; wr_src = 1'b0; wr_en = 1'b1; #2;
      chk("R4 old value", {16'h0, rd_val_a}, {16'h0, 16'h1111});
      @(negedge clk); wr_en = 1'b0; #2;
      chk("R4 new value", {16'h0, rd_val_a}, {16'h0, 16'h2222});
   endtask

   task automatic t_arith;
      load_reg(3'd0, 16'h7FFF); load_reg(3'd1, 16'h0001);
      load_reg(3'd2, 16'h0003); load_reg(3'd3, 16'h0005);
      set_ops(3'd0, 3'd1, 3'd1);
      chk("R5 add wrap", {16'h0, result}, {16'h0, 16'h8000});
      set_ops(3'd2, 3'd3, 3'd2);
      chk("R5 sub negative", {16'h0, result}, {16'h0, 16'hFFFE});
      set_ops(3'd3, 3'd3, 3'd2);
      chk("R5 sub self", {16'h0, result}, 32'h0);
      chk("R6 hi quiet", {16'h0, prod_hi}, 32'h0);
   endtask

   task automatic t_mul;
      load_reg(3'd0, 16'd300); load_reg(3'd1, 16'hFFFE);
      set_ops(3'd0, 3'd1, 3'd3);
      chk("R6 mul neg", {prod_hi, result}, 32'hFFFFFDA8);
      load_reg(3'd0, 16'h4000); load_reg(3'd1, 16'h0004);
      set_ops(3'd0, 3'd1, 3'd3);
      chk("R6 mul carry", {prod_hi, result}, 32'h00010000);
      load_reg(3'd0, 16'h7FFF); load_reg(3'd1, 16'h7FFF);
      set_ops(3'd0, 3'd1, 3'd3);
      chk("R6 mul max", {prod_hi, result}, 32'h3FFF0001);
      load_reg(3'd0, 16'hFFFF); load_reg(3'd1, 16'hFFFF);
      set_ops(3'd0, 3'd1, 3'd3);
      chk("R6 mul minus ones", {prod_hi, result}, 32'h00000001);
   endtask

   task automatic t_nand;
      load_reg(3'd5, 16'hFF00); load_reg(3'd6, 16'h0FF0);
      set_ops(3'd5, 3'd6, 3'd4);
      chk("R7 nand", {16'h0, result}, {16'h0, 16'hF0FF});
   endtask

   task automatic t_shift;
      load_reg(3'd0, 16'h8001); load_reg(3'd1, 16'h0001); load_reg(3'd2, 16'h000F);
      set_ops(3'd0, 3'd1, 3'd5);
      chk("R8 shl drop msb", {16'h0, result}, {16'h0, 16'h0002});
      set_ops(3'd0, 3'd2, 3'd6);
      chk("R8 shr by 15", {16'h0, result}, {16'h0, 16'h0001});
      load_reg(3'd3, 16'h00F0); load_reg(3'd4, 16'h0013);
      set_ops(3'd3, 3'd4, 3'd5);
      chk("R8 amount low bits", {16'h0, result}, {16'h0, 16'h0780});
      load_reg(3'd3, 16'hF000); load_reg(3'd4, 16'h0004);
      set_ops(3'd3, 3'd4, 3'd6);
      chk("R8 shr zero fill", {16'h0, result}, {16'h0, 16'h0F00});
      load_reg(3'd4, 16'h0010);
      set_ops(3'd3, 3'd4, 3'd5);
      chk("R8 shift zero", {16'h0, result}, {16'h0, 16'hF000});
   endtask

   task automatic t_flags;
      load_reg(3'd0, 16'h0000); load_reg(3'd1, 16'h8000); load_reg(3'd2, 16'h0005);
      set_ops(3'd0, 3'd0, 3'd7);
      chk("R9 test result", {16'h0, result}, 32'h0);
      @(negedge clk); op = 3'd0; #2;
      chk("R9 zero flags", {30'h0, flag_z, flag_n}, 32'h2);
      set_ops(3'd1, 3'd1, 3'd7);
      @(negedge clk); op = 3'd0; #2;
      chk("R9 neg flags", {30'h0, flag_z, flag_n}, 32'h1);
      set_ops(3'd2, 3'd2, 3'd0);
      chk("R10 idle result", {prod_hi, result}, 32'h0);
      @(negedge clk); #2;
      chk("R10 idle flags", {30'h0, flag_z, flag_n}, 32'h1);
      set_ops(3'd0, 3'd0, 3'd2);
      @(negedge clk); #2;
      chk("R10 sub keeps flags", {30'h0, flag_z, flag_n}, 32'h1);
      @(negedge clk); rst = 1'b1; op = 3'd0;
      @(negedge clk); rst = 1'b0; #2;
      chk("R1 reset flags", {30'h0, flag_z, flag_n}, 32'h0);
      chk("R1 reset regs", {16'h0, rd_val_a}, 32'h0);
   endtask

   task automatic t_writeback;
      load_reg(3'd1, 16'd5); load_reg(3'd2, 16'd7);
      @(negedge clk);
      rd_sel_a = 3'd1; rd_sel_b = 3'd2; op = 3'd1;
      wr_sel = 3'd1; wr_src = 1'b1; ext_data = 16'hAAAA; wr_en = 1'b1; #2;
      chk("R11 sum before edge", {16'h0, result}, 32'd12);
      chk("R4 source old", {16'h0, rd_val_a}, 32'd5);
      @(negedge clk); wr_en = 1'b0; #2;
      chk("R11 written back", {16'h0, rd_val_a}, 32'd12);
      chk("R11 chained sum", {16'h0, result}, 32'd19);
      wr_src = 1'b0;
   endtask

   initial begin
      #(20 * 150000);
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst = 1'b1; rd_sel_a = '0; rd_sel_b = '0; wr_sel = '0;
      wr_en = 1'b0; wr_src = 1'b0; ext_data = '0; op = '0;
      repeat (2) @(negedge clk);
      t_reset();
      t_fill_read();
      t_write_gate();
      t_same_cycle();
      t_arith();
      t_mul();
      t_nand();
      t_shift();
      t_flags();
      t_writeback();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule